// File: doc/BRIEF.md
# Zero-Input Limit Cycle Monitor

This block watches the output stream of a fixed-point controller while the controller runs on an all-zero input. Before the test, the controller's past outputs are preloaded with chosen values. Outside logic then feeds it zeros, and every output word it produces reaches this monitor with a valid strobe. The monitor decides whether the free response dies out or gets stuck in a self-sustaining oscillation. For this test the controller is expected to wrap on overflow, not saturate, so that an oscillation driven by wrap-around is not hidden.

A start pulse arms the monitor, wipes the sample history and latches the observation length. Every accepted sample is shifted into a short history. On each cycle the monitor compares the newest window of P samples with the P samples just before it, for every period P up to a parameter limit. A matching window that is not all zero is recorded as a limit cycle. When the observation length has been used up, the monitor raises done. It reports pass or fail, and on a fail it also reports the shortest period it found. The observation length is never allowed to fall below the number of fractional bits of the controller's word format.

Top module: `zero_input_cycle_monitor`

## Requirements
- R1: After reset, done_o and fail_o are low and period_o is zero.
- R2: A start pulse empties the sample history, clears any earlier result and begins a new observation, even while one is running. In the cycle after start, done_o and fail_o are low.
- R3: A sample is taken only when sample_valid_i is high, an observation is running, start_i is low and fewer samples than the effective length have been taken. Any other sample has no effect on the result.
- R4: The effective length is obs_len_i latched at start, raised to FRAC_BITS when it is smaller.
- R5: done_o rises on the clock edge after the edge that takes the last sample. It stays high, with fail_o and period_o unchanged, until the next start.
- R6: A limit cycle is flagged if, at any point during the observation, the last P samples taken equal the P samples taken just before them word for word, for some P from 1 to MAX_PER. At least 2P samples must have been taken, and the last P must not all be zero. The flag stays set for the rest of the observation.
- R7: A response that reaches zero and stays there, or that never repeats with a period up to MAX_PER, gives done_o with fail_o low.
- R8: On a fail, period_o holds the smallest matching P from the first cycle in which any match was seen. Otherwise period_o is zero.
- R9: fail_o is never high while done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Arms a new observation and clears history and result |
| sample_valid_i | input | 1 | Qualifies sample_i |
| sample_i | input | DATA_W | Controller output word, two's complement |
| obs_len_i | input | LEN_W | Requested number of samples to observe, latched at start |
| done_o | output | 1 | Observation finished; result valid |
| fail_o | output | 1 | A nonzero repeating pattern was seen |
| period_o | output | PER_W | Period of the detected cycle, zero on pass |

## Verification
Each sample is taken on the edge where its strobe is seen. The comparison acts on the stored history in the following cycle, so a match becomes visible only through the verdict. The verdict and done_o appear on the edge after the edge that took the last sample, and done_o and fail_o read low in the cycle after a start. The bench's behavioural model applies the same edge-by-edge bookkeeping to a queue of taken samples. It predicts all three outputs, which are compared at every falling edge, and directed checks sample the final-sample-plus-one edge and the edges just before it.

// File: rtl/zicm_pkg.sv
package zicm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } zicm_state_e;
endpackage

// File: rtl/zicm_history.sv
module zicm_history #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear_i,
  input  logic                          accept_i,
  input  logic [DATA_W-1:0]             din_i,
  output logic [DEPTH-1:0][DATA_W-1:0]  hist_o
);
  logic [DEPTH-1:0][DATA_W-1:0] hist_q, hist_d;
  logic                         hist_en;

  // index 0 holds the newest word
  always_comb begin
    hist_en = clear_i | accept_i;
    if (clear_i) hist_d = '0;
    else         hist_d = {hist_q[DEPTH-2:0], din_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (hist_en) hist_q <= hist_d;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/zicm_period_match.sv
module zicm_period_match #(
  parameter int DATA_W  = 16,
  parameter int MAX_PER = 4,
  parameter int LEN_W   = 12,
  parameter int PER_W   = 3
) (
  input  logic [2*MAX_PER-1:0][DATA_W-1:0] hist_i,
  input  logic [LEN_W-1:0]                 cnt_i,
  output logic                             any_o,
  output logic [PER_W-1:0]                 per_o
);
  logic [MAX_PER-1:0] hit_vec;

  for (genvar p = 1; p <= MAX_PER; p++) begin : g_per
    logic eq, nz;
    always_comb begin
      eq = 1'b1;
      nz = 1'b0;
      for (int i = 0; i < p; i++) begin
        if (hist_i[i] != hist_i[i+p]) eq = 1'b0;
        if (hist_i[i] != '0)          nz = 1'b1;
      end
    end
    assign hit_vec[p-1] = eq & nz & (cnt_i >= LEN_W'(2*p));
  end

  // shortest period wins
  always_comb begin
    per_o = '0;
    for (int p = MAX_PER; p >= 1; p--) begin
      if (hit_vec[p-1]) per_o = PER_W'(p);
    end
  end

  assign any_o = |hit_vec;
endmodule

// File: rtl/zicm_ctrl.sv
module zicm_ctrl
  import zicm_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int PER_W     = 3,
  parameter int FRAC_BITS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [LEN_W-1:0] obs_len_i,
  input  logic             match_any_i,
  input  logic [PER_W-1:0] match_per_i,
  output logic             clear_o,
  output logic             accept_o,
  output logic [LEN_W-1:0] cnt_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [PER_W-1:0] period_o
);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(FRAC_BITS);

  zicm_state_e      st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic             hit_q, hit_d, fail_q, fail_d;
  logic [PER_W-1:0] hp_q, hp_d, pout_q, pout_d;
  logic             upd_en;

  always_comb begin
    st_d = st_q;  cnt_d = cnt_q;  len_d = len_q;
    hit_d = hit_q; hp_d = hp_q;  fail_d = fail_q; pout_d = pout_q;
    clear_o = 1'b0; accept_o = 1'b0;
    upd_en = start_i | (st_q == ST_RUN);
    if (start_i) begin
      st_d    = ST_RUN;
      cnt_d   = '0;
      len_d   = (obs_len_i < MIN_LEN) ? MIN_LEN : obs_len_i;
      hit_d   = 1'b0;
      hp_d    = '0;
      fail_d  = 1'b0;
      pout_d  = '0;
      clear_o = 1'b1;
    end else if (st_q == ST_RUN) begin
      if (!hit_q && match_any_i) begin
        hit_d = 1'b1;
        hp_d  = match_per_i;
      end
      if (cnt_q == len_q) begin
        st_d   = ST_FIN;
        fail_d = hit_q | match_any_i;
        pout_d = hit_q ? hp_q : (match_any_i ? match_per_i : '0);
      end else if (valid_i) begin
        accept_o = 1'b1;
        cnt_d    = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; len_q <= '0;
      hit_q <= 1'b0; hp_q <= '0; fail_q <= 1'b0; pout_q <= '0;
    end else if (upd_en) begin
      st_q <= st_d; cnt_q <= cnt_d; len_q <= len_d;
      hit_q <= hit_d; hp_q <= hp_d; fail_q <= fail_d; pout_q <= pout_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign done_o   = (st_q == ST_FIN);
  assign fail_o   = fail_q;
  assign period_o = pout_q;
endmodule

// File: rtl/zero_input_cycle_monitor.sv
module zero_input_cycle_monitor #(
  parameter int DATA_W    = 16,
  parameter int MAX_PER   = 4,
  parameter int LEN_W     = 12,
  parameter int FRAC_BITS = 6,
  parameter int PER_W     = $clog2(MAX_PER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sample_valid_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [LEN_W-1:0]  obs_len_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [PER_W-1:0]  period_o
);
  localparam int HIST_D = 2 * MAX_PER;

  logic [1:0]                    rst_sync_q;
  logic                          rst_int_n;
  logic                          clear, accept, match_any;
  logic [LEN_W-1:0]              cnt;
  logic [PER_W-1:0]              match_per;
  logic [HIST_D-1:0][DATA_W-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  zicm_history #(.DATA_W(DATA_W), .DEPTH(HIST_D)) u_hist (
    .clk(clk), .rst_n(rst_int_n), .clear_i(clear), .accept_i(accept),
    .din_i(sample_i), .hist_o(hist)
  );

  zicm_period_match #(.DATA_W(DATA_W), .MAX_PER(MAX_PER), .LEN_W(LEN_W), .PER_W(PER_W)) u_match (
    .hist_i(hist), .cnt_i(cnt), .any_o(match_any), .per_o(match_per)
  );

  zicm_ctrl #(.LEN_W(LEN_W), .PER_W(PER_W), .FRAC_BITS(FRAC_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .valid_i(sample_valid_i),
    .obs_len_i(obs_len_i), .match_any_i(match_any), .match_per_i(match_per),
    .clear_o(clear), .accept_o(accept), .cnt_o(cnt),
    .done_o(done_o), .fail_o(fail_o), .period_o(period_o)
  );
endmodule

// File: rtl/zicm_checker.sv
module zicm_checker #(
  parameter int MAX_PER = 4,
  parameter int PER_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             done_o,
  input logic             fail_o,
  input logic [PER_W-1:0] period_o
);
  assert_fail_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> done_o);

  assert_period_zero_on_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_o |-> (period_o == '0));

  assert_period_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (period_o != '0 && period_o <= PER_W'(MAX_PER)));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && !fail_o));

  assert_result_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(fail_o) && $stable(period_o)));
endmodule

bind zero_input_cycle_monitor zicm_checker #(.MAX_PER(MAX_PER), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .done_o(done_o), .fail_o(fail_o), .period_o(period_o)
);

// File: tb/tb_zero_input_cycle_monitor.sv
module tb_zero_input_cycle_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16, MAX_PER = 4, LEN_W = 12, FRAC_BITS = 6;
  localparam int PER_W = $clog2(MAX_PER + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, sample_valid_i = 1'b0;
  logic [DATA_W-1:0] sample_i = '0;
  logic [LEN_W-1:0]  obs_len_i = '0;
  logic done_o, fail_o;
  logic [PER_W-1:0] period_o;

  int checks = 0, failures = 0, cycles = 0;
  bit cmp_en = 1'b0;

  zero_input_cycle_monitor #(.DATA_W(DATA_W), .MAX_PER(MAX_PER), .LEN_W(LEN_W),
    .FRAC_BITS(FRAC_BITS)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int  hq[$];
  int  m_state = 0, m_len = 0, m_hp = 0, m_pout = 0;
  bit  m_hit = 0, m_fail = 0;

  function automatic void find_cycle(input int h[$], output bit f, output int per);
    f = 0; per = 0;
    for (int p = MAX_PER; p >= 1; p--) begin
      if (h.size() >= 2*p) begin
        bit eq, nz;
        eq = 1; nz = 0;
        for (int i = 0; i < p; i++) begin
          if (h[h.size()-1-i] != h[h.size()-1-i-p]) eq = 0;
          if (h[h.size()-1-i] != 0) nz = 1;
        end
        if (eq && nz) begin f = 1; per = p; end
      end
    end
  endfunction

  always @(posedge clk) begin
    bit f; int per;
    if (!rst_n) begin
      hq.delete(); m_state = 0; m_len = 0; m_hit = 0; m_hp = 0; m_fail = 0; m_pout = 0;
    end else if (start_i) begin
      hq.delete(); m_state = 1; m_hit = 0; m_hp = 0; m_fail = 0; m_pout = 0;
      m_len = (int'(obs_len_i) < FRAC_BITS) ? FRAC_BITS : int'(obs_len_i);
    end else if (m_state == 1) begin
      find_cycle(hq, f, per);
      if (hq.size() == m_len) begin
        m_state = 2;
        m_fail  = m_hit | f;
        m_pout  = m_hit ? m_hp : (f ? per : 0);
      end else if (sample_valid_i) begin
        hq.push_back(int'(sample_i));
      end
      if (!m_hit && f) begin m_hit = 1; m_hp = per; end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cmp_en) begin
      chk(done_o == (m_state == 2), "R5 done vs model", int'(done_o), int'(m_state == 2));
      chk(fail_o == m_fail, "R6 fail vs model", int'(fail_o), int'(m_fail));
      chk(int'(period_o) == m_pout, "R8 period vs model", int'(period_o), m_pout);
    end
    if (cycles > 100000) begin
      chk(0, "watchdog", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(input int vals[$], input int len, input bit gaps, input bit with_valid);
    @(negedge clk);
    start_i = 1; obs_len_i = LEN_W'(len);
    sample_valid_i = with_valid; sample_i = 16'd9;
    @(negedge clk);
    start_i = 0;
    chk(!done_o && !fail_o, "R2 cleared after start", int'(done_o | fail_o), 0);
    foreach (vals[k]) begin
      sample_valid_i = 1; sample_i = DATA_W'(vals[k]);
      @(negedge clk);
      if (gaps) begin
        sample_valid_i = 0; sample_i = 16'h5A5A;
        @(negedge clk);
      end
    end
    sample_valid_i = 0;
    for (int w = 0; w < 40 && !done_o; w++) @(negedge clk);
  endtask

  task automatic verdict(input string req, input bit ef, input int ep);
    chk(done_o, req, int'(done_o), 1);
    chk(fail_o == ef, req, int'(fail_o), int'(ef));
    chk(int'(period_o) == ep, req, int'(period_o), ep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!done_o && !fail_o && period_o == 0, "R1 reset state", int'(done_o | fail_o), 0);
    cmp_en = 1;

    run('{7, 3, -3, 3, -3, 3, -3, 3, -3, 3}, 10, 0, 0);
    verdict("R6 period-2 oscillation", 1, 2);

    run('{40, 20, 10, 5, 2, 1, 0, 0, 0, 0}, 10, 0, 0);
    verdict("R7 decay to zero passes", 0, 0);

    run('{2, 2, 2, 2, 2, 2, 2, 2}, 8, 0, 0);
    verdict("R8 constant gives period 1", 1, 1);

    run('{1, 2, 3, 1, 2, 3, 1, 2, 3, 1, 2, 3}, 12, 0, 0);
    verdict("R6 period-3 pattern", 1, 3);

    run('{1, 0, 0, 0, 1, 0, 0, 0}, 8, 0, 0);
    verdict("R6 longest period", 1, 4);

    run('{1, 2, 3, 4, 5, 1, 2, 3, 4, 5, 1, 2, 3, 4, 5}, 15, 0, 0);
    verdict("R7 period above limit passes", 0, 0);

    run('{5, 5, 0, 0, 0, 0}, 6, 0, 0);
    verdict("R6 sticky after decay", 1, 1);

    run('{-4, 6, -4, 6, -4, 6, -4, 6}, 8, 1, 1);
    verdict("R3 gaps and start-cycle sample ignored", 1, 2);

    // R4 / R5: requested length 2 is raised to FRAC_BITS
    @(negedge clk);
    start_i = 1; obs_len_i = 2;
    @(negedge clk);
    start_i = 0;
    for (int k = 0; k < 2; k++) begin
      sample_valid_i = 1; sample_i = DATA_W'(10 + k); @(negedge clk);
    end
    sample_valid_i = 0;
    repeat (3) @(negedge clk);
    chk(!done_o, "R4 short length not honoured", int'(done_o), 0);
    for (int k = 2; k < FRAC_BITS; k++) begin
      sample_valid_i = 1; sample_i = DATA_W'(10 + k); @(negedge clk);
    end
    sample_valid_i = 1; sample_i = 16'd7;
    chk(!done_o, "R5 not done on final sample edge", int'(done_o), 0);
    @(negedge clk);
    sample_valid_i = 0;
    chk(done_o && !fail_o, "R5 done one edge after last sample", int'(done_o), 1);
    repeat (4) @(negedge clk);
    chk(done_o && !fail_o && period_o == 0, "R5 result held; R3 extra sample ignored",
        int'(done_o), 1);

    // R2: restart in mid-run discards a pending match
    run('{4, 4, 4}, 20, 0, 0);
    run('{9, 3, 1, 0, 0, 0, 0, 0}, 8, 0, 0);
    verdict("R2 restart clears history", 0, 0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule